// File: doc/BRIEF.md
# Vector Arithmetic Lane Sequencer

This block executes one whole-vector arithmetic operation on two operand vectors of `VLEN` signed fixed-point elements (64 bits, 32 of them fractional). A controller raises `start_i` for one cycle with an operation code and both operand vectors. The block captures them and returns one result vector together with a single-cycle `done_o` pulse.

Inside the block there are three pools of arithmetic lanes. One pool adds or subtracts, one multiplies and one divides, and each pool has its own lane-count parameter that is chosen freely against the vector length. When a pool has fewer lanes than the vector has elements, the block walks the vector in ascending chunks. It feeds each chunk to the lanes and writes the lane outputs back into the result vector. Lanes left over in a short final chunk are idle and their outputs are discarded. The adder and multiplier lanes are combinational. The divider lanes are sequential restoring dividers, and the block waits for them before it moves to the next chunk. The controller sees none of this.

Top module: `vec_alu_seq`

## Requirements
- R1: After reset `busy_o` and `done_o` are low and every element of `res_o` is zero.
- R2: Operation code 2'b00 gives the element-wise sum and 2'b01 the element-wise difference (A minus B), both wrapping modulo 2^64.
- R3: Operation code 2'b10 gives bits [95:32] of the full 128-bit signed product of each element pair, which rounds toward negative infinity.
- R4: Operation code 2'b11 gives the quotient A/B scaled by 2^32, truncated toward zero. A result above 0x7FFF_FFFF_FFFF_FFFF clamps to that value, and a result below 0x8000_0000_0000_0000 clamps to that value. A zero divisor returns 0x8000_0000_0000_0000 for a negative dividend and 0x7FFF_FFFF_FFFF_FFFF otherwise.
- R5: With N lanes for the selected operator, elements are processed in ceil(VLEN/N) ascending passes. For add, subtract and multiply, `done_o` is high in the cycle that follows the P-th rising edge after the edge that accepted `start_i`, where P is the pass count.
- R6: For divide, each pass takes 66 clock edges: one issue edge, 64 iteration edges and one write edge. `done_o` is high after the 66*P-th edge following the accepting edge.
- R7: `busy_o` rises on the accepting edge and falls on the edge that raises `done_o`. `done_o` lasts exactly one cycle and is never high together with `busy_o`.
- R8: `start_i` is ignored while `busy_o` is high. The operation in flight keeps its captured operation code, operands and timing.
- R9: `res_o` holds its value from `done_o` until the next accepted `start_i`, whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Requests a vector operation when the block is idle |
| op_i | input | 2 | Operation code: 00 add, 01 subtract, 10 multiply, 11 divide |
| opa_i | input | VLEN*64 | Operand vector A, element e at bits [64e+63:64e] |
| opb_i | input | VLEN*64 | Operand vector B, same element layout |
| busy_o | output | 1 | High while an operation is in flight |
| done_o | output | 1 | Single-cycle pulse when the whole result vector is complete |
| res_o | output | VLEN*64 | Result vector, same element layout |

## Verification
The bench builds the block with a vector length of 24, eight adder lanes, five multiplier lanes and seven divider lanes. With these counts all three pools need several passes, and the multiplier and divider pools end on a partial final chunk in which lanes sit unused. The divider corner values are placed on both sides of a chunk boundary. A reference model written as plain behaviour predicts `busy_o` and `done_o` for every cycle and the value of every result element. The bench also pulses `start_i` while the block is busy and changes the operands while it is idle, to show that neither has any effect.

// File: rtl/vsq_pkg.sv
package vsq_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_MUL = 2'b10,
        OP_DIV = 2'b11
    } vop_e;

    typedef enum logic [1:0] {
        PH_IDLE      = 2'b00,
        PH_ARITH     = 2'b01,
        PH_DIV_ISSUE = 2'b10,
        PH_DIV_WAIT  = 2'b11
    } phase_e;

endpackage

// File: rtl/vsq_lane_addsub.sv
module vsq_lane_addsub #(
    parameter int W = 64
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] y_o
);
    // Two's complement add or subtract; the carry out is dropped (wraps).
    always_comb begin
        if (sub_i) y_o = a_i - b_i;
        else       y_o = a_i + b_i;
    end
endmodule

// File: rtl/vsq_lane_mul.sv
module vsq_lane_mul #(
    parameter int W    = 64,
    parameter int FRAC = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);
    logic signed [2*W-1:0] prod;

    always_comb begin
        prod = (2*W)'($signed(a_i)) * (2*W)'($signed(b_i));
        // Slicing a two's complement product rounds toward negative infinity.
        y_o  = prod[W+FRAC-1:FRAC];
    end
endmodule

// File: rtl/vsq_lane_div.sv
module vsq_lane_div #(
    parameter int W    = 64,
    parameter int FRAC = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         go_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o,
    output logic         rdy_o
);
    localparam int CW = $clog2(W + 1);
    localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINN = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [W-1:0]  rem;
        logic [W-1:0]  shr;
        logic [W-1:0]  quo;
        logic [W-1:0]  dvs;
        logic          neg;
        logic          sat;
        logic          zdiv;
        logic          rdy;
    } dst_t;

    dst_t s_d, s_q;
    logic [W-1:0] ma, mb, hi;
    logic [W:0]   trial, diff;

    always_comb begin
        s_d   = s_q;
        ma    = a_i[W-1] ? (~a_i + 1'b1) : a_i;
        mb    = b_i[W-1] ? (~b_i + 1'b1) : b_i;
        hi    = ma >> (W - FRAC);
        trial = {s_q.rem, s_q.shr[W-1]};
        diff  = trial - {1'b0, s_q.dvs};
        if (go_i) begin
            // The upper quotient bits are all zero unless hi >= divisor, so
            // they collapse into one compare and W iterations remain.
            s_d.cnt  = CW'(W);
            s_d.rem  = hi;
            s_d.shr  = ma << FRAC;
            s_d.quo  = '0;
            s_d.dvs  = mb;
            s_d.zdiv = (mb == '0);
            s_d.sat  = (mb == '0) || (hi >= mb);
            s_d.neg  = (mb == '0) ? a_i[W-1] : (a_i[W-1] ^ b_i[W-1]);
            s_d.rdy  = 1'b0;
        end else if (s_q.cnt != '0) begin
            if (trial >= {1'b0, s_q.dvs}) begin
                s_d.rem = diff[W-1:0];
                s_d.quo = {s_q.quo[W-2:0], 1'b1};
            end else begin
                s_d.rem = trial[W-1:0];
                s_d.quo = {s_q.quo[W-2:0], 1'b0};
            end
            s_d.shr = s_q.shr << 1;
            s_d.cnt = s_q.cnt - CW'(1);
            if (s_q.cnt == CW'(1)) s_d.rdy = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    always_comb begin
        if (!s_q.neg) y_o = (s_q.sat || s_q.quo[W-1]) ? MAXP : s_q.quo;
        else          y_o = (s_q.sat || (s_q.quo > MINN)) ? MINN : (~s_q.quo + 1'b1);
    end
    assign rdy_o = s_q.rdy;

    // R6: loading a new divide always withdraws the ready flag
    p_load_clears_rdy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        go_i |=> !rdy_o);
    // R6: a finished lane stays ready until it is loaded again
    p_rdy_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rdy_o && !go_i) |=> rdy_o);
    // R4: a zero divisor always ends on one of the two clamp values
    p_zero_div_clamp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rdy_o && s_q.zdiv) |-> (y_o == MAXP || y_o == MINN));
endmodule

// File: rtl/vec_alu_seq.sv
module vec_alu_seq
    import vsq_pkg::*;
#(
    parameter int W     = 64,
    parameter int FRAC  = 32,
    parameter int VLEN  = 24,
    parameter int N_ADD = 8,
    parameter int N_MUL = 8,
    parameter int N_DIV = 24
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic [VLEN*W-1:0] opa_i,
    input  logic [VLEN*W-1:0] opb_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [VLEN*W-1:0] res_o
);
    localparam int NMX  = (N_ADD > N_MUL) ? N_ADD : N_MUL;
    localparam int NMAX = (NMX > N_DIV) ? NMX : N_DIV;
    localparam int IW   = $clog2(VLEN + NMAX + 1);

    typedef logic [VLEN-1:0][W-1:0] vec_t;

    typedef struct packed {
        phase_e        phase;
        vop_e          op;
        logic [IW-1:0] base;
        logic          done;
        vec_t          a;
        vec_t          b;
        vec_t          res;
    } st_t;

    st_t s_d, s_q;

    logic [N_ADD-1:0][W-1:0] add_a, add_b, add_y;
    logic [N_MUL-1:0][W-1:0] mul_a, mul_b, mul_y;
    logic [N_DIV-1:0][W-1:0] div_a, div_b, div_y;
    logic [N_DIV-1:0]        div_rdy;
    logic                    div_go;
    logic [IW-1:0]           n_act;
    logic                    last_pass;

    // Select element idx of a vector; out-of-range lanes receive zero.
    function automatic logic [W-1:0] pick(input vec_t v, input logic [IW-1:0] idx);
        logic [W-1:0] r;
        r = '0;
        for (int e = 0; e < VLEN; e++)
            if (IW'(e) == idx) r = v[e];
        return r;
    endfunction

    always_comb begin
        for (int i = 0; i < N_ADD; i++) begin
            add_a[i] = pick(s_q.a, s_q.base + IW'(i));
            add_b[i] = pick(s_q.b, s_q.base + IW'(i));
        end
        for (int i = 0; i < N_MUL; i++) begin
            mul_a[i] = pick(s_q.a, s_q.base + IW'(i));
            mul_b[i] = pick(s_q.b, s_q.base + IW'(i));
        end
        for (int i = 0; i < N_DIV; i++) begin
            div_a[i] = pick(s_q.a, s_q.base + IW'(i));
            div_b[i] = pick(s_q.b, s_q.base + IW'(i));
        end
    end

    assign div_go = (s_q.phase == PH_DIV_ISSUE);

    for (genvar g = 0; g < N_ADD; g++) begin : g_add
        vsq_lane_addsub #(.W(W)) u_lane (
            .a_i  (add_a[g]),
            .b_i  (add_b[g]),
            .sub_i(s_q.op == OP_SUB),
            .y_o  (add_y[g])
        );
    end

    for (genvar g = 0; g < N_MUL; g++) begin : g_mul
        vsq_lane_mul #(.W(W), .FRAC(FRAC)) u_lane (
            .a_i(mul_a[g]),
            .b_i(mul_b[g]),
            .y_o(mul_y[g])
        );
    end

    for (genvar g = 0; g < N_DIV; g++) begin : g_div
        vsq_lane_div #(.W(W), .FRAC(FRAC)) u_lane (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .go_i  (div_go),
            .a_i   (div_a[g]),
            .b_i   (div_b[g]),
            .y_o   (div_y[g]),
            .rdy_o (div_rdy[g])
        );
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.op)
            OP_MUL:  n_act = IW'(N_MUL);
            OP_DIV:  n_act = IW'(N_DIV);
            default: n_act = IW'(N_ADD);
        endcase
        last_pass = (s_q.base + n_act) >= IW'(VLEN);

        unique case (s_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    s_d.op    = vop_e'(op_i);
                    s_d.a     = opa_i;
                    s_d.b     = opb_i;
                    s_d.base  = '0;
                    s_d.phase = (vop_e'(op_i) == OP_DIV) ? PH_DIV_ISSUE : PH_ARITH;
                end
            end
            PH_ARITH: begin
                for (int e = 0; e < VLEN; e++) begin
                    if (s_q.op == OP_MUL) begin
                        for (int i = 0; i < N_MUL; i++)
                            if (IW'(e) == s_q.base + IW'(i)) s_d.res[e] = mul_y[i];
                    end else begin
                        for (int i = 0; i < N_ADD; i++)
                            if (IW'(e) == s_q.base + IW'(i)) s_d.res[e] = add_y[i];
                    end
                end
                if (last_pass) begin
                    s_d.phase = PH_IDLE;
                    s_d.done  = 1'b1;
                end else begin
                    s_d.base = s_q.base + n_act;
                end
            end
            PH_DIV_ISSUE: s_d.phase = PH_DIV_WAIT;
            PH_DIV_WAIT: begin
                if (&div_rdy) begin
                    for (int e = 0; e < VLEN; e++)
                        for (int i = 0; i < N_DIV; i++)
                            if (IW'(e) == s_q.base + IW'(i)) s_d.res[e] = div_y[i];
                    if (last_pass) begin
                        s_d.phase = PH_IDLE;
                        s_d.done  = 1'b1;
                    end else begin
                        s_d.base  = s_q.base + n_act;
                        s_d.phase = PH_DIV_ISSUE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign busy_o = (s_q.phase != PH_IDLE);
    assign done_o = s_q.done;
    assign res_o  = s_q.res;

    // R7: done is a one-cycle pulse
    p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
    // R7: done and busy never overlap
    p_done_not_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);
    // R8: a start request during an operation leaves the captured command alone
    p_start_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i) |=> ($stable(s_q.op) && $stable(s_q.a) && $stable(s_q.b)));
    // R9: the result holds while idle with no start request
    p_result_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !start_i) |=> $stable(res_o));
    // R6: every divide issue edge is followed by the wait phase
    p_issue_then_wait_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.phase == PH_DIV_ISSUE) |=> (s_q.phase == PH_DIV_WAIT));
endmodule

// File: tb/vec_alu_seq_tb_top.sv
module vec_alu_seq_tb_top;
    localparam int VLEN  = 24;
    localparam int NA    = 8;
    localparam int NM    = 5;
    localparam int ND    = 7;
    localparam logic [63:0] MAXP = 64'h7FFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] MINN = 64'h8000_0000_0000_0000;
    localparam logic [63:0] ONE  = 64'h0000_0001_0000_0000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start;
    logic [1:0]        op;
    logic [VLEN*64-1:0] opa, opb, res;
    logic              busy, done;

    int errors = 0;
    int checks = 0;
    logic [63:0] seed = 64'h1234_5678_9ABC_DEF1;
    logic [63:0] ea [VLEN];
    logic [63:0] eb [VLEN];
    logic [63:0] ey [VLEN];

    always #2ns clk = ~clk;

    vec_alu_seq #(.VLEN(VLEN), .N_ADD(NA), .N_MUL(NM), .N_DIV(ND)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
        .opa_i(opa), .opb_i(opb), .busy_o(busy), .done_o(done), .res_o(res)
    );

    function automatic logic [63:0] rnd();
        seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
        return {seed[31:0], seed[63:32]} ^ (seed >> 17);
    endfunction

    function automatic logic [63:0] ref_mul(input logic [63:0] a, input logic [63:0] b);
        logic signed [127:0] p;
        p = 128'($signed(a)) * 128'($signed(b));
        return p[95:32];
    endfunction

    function automatic logic [63:0] ref_div(input logic [63:0] a, input logic [63:0] b);
        logic [63:0]  ma, mb;
        logic [127:0] q;
        ma = a[63] ? -a : a;
        mb = b[63] ? -b : b;
        if (mb == 64'd0) return a[63] ? MINN : MAXP;
        q = ({64'd0, ma} << 32) / {64'd0, mb};
        if (!(a[63] ^ b[63])) return (q > {64'd0, MAXP}) ? MAXP : q[63:0];
        return (q > {64'd0, MINN}) ? MINN : (~q[63:0] + 64'd1);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int passes(input int n);
        return (VLEN + n - 1) / n;
    endfunction

    // Runs one operation from ea/eb, comparing busy/done every cycle.
    task automatic run(input logic [1:0] code, input bit poke);
        string tag;
        int    lat;
        for (int e = 0; e < VLEN; e++) begin
            unique case (code)
                2'b00: ey[e] = ea[e] + eb[e];
                2'b01: ey[e] = ea[e] - eb[e];
                2'b10: ey[e] = ref_mul(ea[e], eb[e]);
                default: ey[e] = ref_div(ea[e], eb[e]);
            endcase
        end
        tag = (code == 2'b10) ? "R3" : (code == 2'b11) ? "R4" : "R2";
        lat = (code == 2'b10) ? passes(NM) : (code == 2'b11) ? 66 * passes(ND) : passes(NA);
        for (int e = 0; e < VLEN; e++) begin
            opa[e*64 +: 64] = ea[e];
            opb[e*64 +: 64] = eb[e];
        end
        op = code;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int j = 0; j <= lat + 1; j++) begin
            chk(busy == (j < lat), "R7", "busy", 64'(busy), 64'(j < lat));
            chk(done == (j == lat), (code == 2'b11) ? "R6" : "R5", "done timing",
                64'(done), 64'(j == lat));
            if (j == lat || j == lat + 1) begin
                for (int e = 0; e < VLEN; e++)
                    chk(res[e*64 +: 64] == ey[e], (j == lat) ? tag : "R9",
                        $sformatf("element %0d", e), res[e*64 +: 64], ey[e]);
                if (poke && j == lat)
                    chk(res[0 +: 64] == ey[0], "R8", "start while busy ignored",
                        res[0 +: 64], ey[0]);
            end
            if (poke && j == 1) begin
                start = 1'b1;
                op    = ~code;
                opa   = ~opa;
            end
            if (poke && j == 2) start = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        op    = 2'b00;
        opa   = '0;
        opb   = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!busy, "R1", "busy after reset", 64'(busy), 64'd0);
        chk(!done, "R1", "done after reset", 64'(done), 64'd0);
        for (int e = 0; e < VLEN; e++)
            chk(res[e*64 +: 64] == 64'd0, "R1", "result after reset", res[e*64 +: 64], 64'd0);

        // R2: add, random data
        for (int e = 0; e < VLEN; e++) begin ea[e] = rnd(); eb[e] = rnd(); end
        run(2'b00, 1'b0);

        // R2 / R8: subtract with wrap corners and a start pulse during busy
        for (int e = 0; e < VLEN; e++) begin ea[e] = rnd(); eb[e] = rnd(); end
        ea[0] = MINN; eb[0] = 64'd1;
        ea[9] = MAXP; eb[9] = MINN;
        run(2'b01, 1'b1);

        // R2: add overflow wraps
        for (int e = 0; e < VLEN; e++) begin ea[e] = MAXP - 64'(e); eb[e] = 64'(e + 1); end
        run(2'b00, 1'b0);

        // R3: multiply, signed corners and rounding toward negative infinity
        for (int e = 0; e < VLEN; e++) begin
            ea[e] = {{16{seed[5]}}, rnd() >> 16};
            eb[e] = {{20{seed[9]}}, rnd() >> 20};
        end
        ea[0] = 64'hFFFF_FFFF_FFFF_FFFF; eb[0] = 64'h0000_0000_8000_0000;
        ea[4] = 3 * ONE;                 eb[4] = -(2 * ONE);
        ea[5] = -(ONE >> 1);             eb[5] = -(ONE >> 1);
        ea[23] = 64'd1;                  eb[23] = 64'd1;
        run(2'b10, 1'b1);

        // R4 / R6: divide corners across chunk boundaries
        for (int e = 0; e < VLEN; e++) begin
            ea[e] = {{8{seed[3]}}, rnd() >> 8};
            eb[e] = {{24{seed[7]}}, rnd() >> 24};
        end
        ea[0] = 5 * ONE;   eb[0] = 2 * ONE;
        ea[1] = -(5 * ONE); eb[1] = 2 * ONE;
        ea[2] = 64'd1;     eb[2] = 64'd0;
        ea[3] = -64'd1;    eb[3] = 64'd0;
        ea[4] = 64'd0;     eb[4] = 64'd0;
        ea[5] = MAXP;      eb[5] = 64'd1;
        ea[6] = MINN;      eb[6] = 64'd1;
        ea[7] = ONE;       eb[7] = 3 * ONE;
        ea[8] = -ONE;      eb[8] = 3 * ONE;
        ea[13] = MINN;     eb[13] = -ONE;
        ea[14] = 64'd0;    eb[14] = -(7 * ONE);
        ea[20] = -(6 * ONE); eb[20] = -(4 * ONE);
        run(2'b11, 1'b1);

        // R4: divide with random operands
        for (int e = 0; e < VLEN; e++) begin
            ea[e] = {{12{seed[2]}}, rnd() >> 12};
            eb[e] = {{30{seed[6]}}, rnd() >> 30};
        end
        run(2'b11, 1'b0);

        // R9: operand inputs change while idle; result must hold
        for (int k = 0; k < 6; k++) begin
            opa = ~opa;
            opb = opb ^ {VLEN{rnd()}};
            op  = 2'(k);
            @(negedge clk);
            chk(!busy, "R9", "stays idle without start", 64'(busy), 64'd0);
            for (int e = 0; e < VLEN; e++)
                chk(res[e*64 +: 64] == ey[e], "R9", "result held", res[e*64 +: 64], ey[e]);
        end

        // R5: back-to-back add after a divide
        for (int e = 0; e < VLEN; e++) begin ea[e] = 64'(e) * ONE; eb[e] = -(64'(e) << 8); end
        run(2'b00, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule